// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers seen by a processor core. It also holds one saved status word for each exception mode. A 4-bit logical register number and the 5-bit processor mode together select the physical storage entry. The physical store is one flat array of 32 words.

- Registers 0 to 7 exist once and every mode shares them.
- Registers 8 to 12 have a second copy that only the fast-interrupt mode uses.
- Registers 13 (stack pointer) and 14 (link) have a separate copy per exception mode.
- The user and system modes share one set of registers and have no saved status word.

There are two combinational read ports and one clocked write port. Register 15 is not stored: reading it returns the external program-counter input, and a write to it is dropped. The write port has its own mode input. Exception-entry logic uses it to load the link register of the target mode while the current mode is still the old one. The saved-status port always follows the current mode.

Top module: `banked_regfile`

## Requirements
- R1: After an active-low reset, every stored register copy and every saved status word reads zero.
- R2: Registers 0–7 are one physical set: a value written in any mode reads back in every mode.
- R3: In fast-interrupt mode (10001), registers 8–14 use a private copy, separate from the user copy and the copies of the other modes.
- R4: Interrupt (10010), supervisor (10011), abort (10111), undefined (11011) and monitor (10110) modes each have a private copy of registers 13 and 14 only. In these modes, registers 8–12 are the user copy.
- R5: User (10000) and system (11111) modes access the same registers. Any mode encoding not listed in R3–R5 maps like user mode.
- R6: A read of index 15 returns pc_i on either port. A write to index 15 changes no stored register.
- R7: Writes take effect at the rising clock edge. A read in the same cycle as a write to the same register returns the old value.
- R8: Writes use wr_mode_i, not mode_i, to select the bank, so another mode's banked register can be written.
- R9: Each of the six exception modes has its own saved status word. It is read on sps_rdata_o and written through sps_we_i while mode_i selects that mode.
- R10: In user, system or an unlisted mode, sps_rdata_o reads zero and saved-status writes store nothing.
- R11: The two read ports decode their indices independently within the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode (read banking, saved-status port) |
| rd_a_idx_i | input | 4 | Read port A logical index |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_idx_i | input | 4 | Read port B logical index |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_mode_i | input | 5 | Mode whose bank the write targets |
| wr_idx_i | input | 4 | Write logical index |
| wr_data_i | input | DATA_W | Write data |
| pc_i | input | DATA_W | Program counter returned for index 15 |
| sps_we_i | input | 1 | Saved-status write enable (current mode) |
| sps_wdata_i | input | DATA_W | Saved-status write data |
| sps_rdata_o | output | DATA_W | Saved-status read data (current mode) |

## Verification
The hardest case to reach is proving that every one of the seven stack-pointer and link copies is private. Reads only show the copy of the mode currently applied, so a write that lands in the wrong bank goes unseen unless that other bank is read later. The bench first writes a distinct value to register 13 in each exception mode. It then re-reads all of them, plus the user copy, after every bank has been written. Cross-mode writes through wr_mode_i are checked the same way: the bench keeps mode_i at user, then switches mode_i to read the target bank.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  typedef enum logic [2:0] {BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_MON} bank_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_MON = 5'b10110;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam int N_SHARED = 8;   // r0-r7
  localparam int N_HIGH   = 5;   // r8-r12
  localparam int N_BANKS  = 7;   // distinct r13/r14 sets
  localparam int N_XBANK  = N_BANKS - 1;  // banks owning a saved status word
  localparam int HIGH_FIQ_BASE = N_SHARED + N_HIGH;
  localparam int SPLR_BASE     = HIGH_FIQ_BASE + N_HIGH;
  localparam int N_PHYS        = SPLR_BASE + 2 * N_BANKS;
  localparam int PHYS_W        = $clog2(N_PHYS);
endpackage

// File: rtl/mode_dec.sv
module mode_dec
  import rbank_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o
);
  always_comb begin
    unique case (mode_i)
      MODE_FIQ: bank_o = BK_FIQ;
      MODE_IRQ: bank_o = BK_IRQ;
      MODE_SVC: bank_o = BK_SVC;
      MODE_ABT: bank_o = BK_ABT;
      MODE_UND: bank_o = BK_UND;
      MODE_MON: bank_o = BK_MON;
      default:  bank_o = BK_USR;  // user, system, unknown
    endcase
  end
endmodule

// File: rtl/phys_map.sv
module phys_map
  import rbank_pkg::*;
(
  input  logic [3:0]        idx_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              is_pc_o
);
  logic [PHYS_W-1:0] idx_w;
  logic [PHYS_W-1:0] bank_w;

  assign idx_w   = PHYS_W'(idx_i);
  assign bank_w  = PHYS_W'(bank_i);
  assign is_pc_o = (idx_i == 4'hf);

  always_comb begin
    if (idx_w < PHYS_W'(N_SHARED))
      phys_o = idx_w;
    else if (idx_w < PHYS_W'(N_SHARED + N_HIGH))
      phys_o = (bank_i == BK_FIQ) ? idx_w + PHYS_W'(HIGH_FIQ_BASE - N_SHARED) : idx_w;
    else
      // r13/r14 pairs: one pair per bank; r15 result is masked by is_pc_o
      phys_o = PHYS_W'(SPLR_BASE) + (bank_w << 1) + (idx_w - PHYS_W'(N_SHARED + N_HIGH));
  end
endmodule

// File: rtl/gpr_array.sv
module gpr_array
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHYS_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PHYS_W-1:0] raddr_a_i,
  input  logic [PHYS_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [N_PHYS];

  for (genvar g = 0; g < N_PHYS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[g] <= '0;
      else if (we_i && waddr_i == PHYS_W'(g))         mem[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

  p_write_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/sps_array.sv
module sps_array
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_e             bank_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N_XBANK-1:0][DATA_W-1:0] mem;
  logic                           has_slot;
  logic [2:0]                     slot;

  assign has_slot = (bank_i != BK_USR);
  assign slot     = 3'(bank_i) - 3'd1;

  for (genvar g = 0; g < N_XBANK; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[g] <= '0;
      else if (we_i && has_slot && slot == 3'(g))    mem[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_XBANK; k++)
      if (has_slot && slot == 3'(k)) rdata_o = mem[k];
  end

  p_sps_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !has_slot) |=> $stable(mem));
  p_sps_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_i == BK_USR) |-> rdata_o == '0);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_mode_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              sps_we_i,
  input  logic [DATA_W-1:0] sps_wdata_i,
  output logic [DATA_W-1:0] sps_rdata_o
);
  bank_e             rd_bank, wr_bank;
  logic [PHYS_W-1:0] ph_a, ph_b, ph_w;
  logic              pc_a, pc_b, pc_w;
  logic [DATA_W-1:0] arr_a, arr_b;

  mode_dec u_rd_dec (.mode_i(mode_i),    .bank_o(rd_bank));
  mode_dec u_wr_dec (.mode_i(wr_mode_i), .bank_o(wr_bank));

  phys_map u_map_a (.idx_i(rd_a_idx_i), .bank_i(rd_bank), .phys_o(ph_a), .is_pc_o(pc_a));
  phys_map u_map_b (.idx_i(rd_b_idx_i), .bank_i(rd_bank), .phys_o(ph_b), .is_pc_o(pc_b));
  phys_map u_map_w (.idx_i(wr_idx_i),   .bank_i(wr_bank), .phys_o(ph_w), .is_pc_o(pc_w));

  gpr_array #(.DATA_W(DATA_W)) u_gpr (
    .clk_i, .rst_ni,
    .we_i(wr_en_i && !pc_w), .waddr_i(ph_w), .wdata_i(wr_data_i),
    .raddr_a_i(ph_a), .raddr_b_i(ph_b),
    .rdata_a_o(arr_a), .rdata_b_o(arr_b)
  );

  sps_array #(.DATA_W(DATA_W)) u_sps (
    .clk_i, .rst_ni,
    .bank_i(rd_bank), .we_i(sps_we_i), .wdata_i(sps_wdata_i), .rdata_o(sps_rdata_o)
  );

  assign rd_a_data_o = pc_a ? pc_i : arr_a;
  assign rd_b_data_o = pc_b ? pc_i : arr_b;

  p_pc_read_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == 4'hf) |-> rd_a_data_o == pc_i);
  p_pc_read_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_idx_i == 4'hf) |-> rd_b_data_o == pc_i);
  p_shared_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i < 4'd8) |-> ph_a == PHYS_W'(rd_a_idx_i));
endmodule

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  localparam int DW = 32;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         MON = 5'b10110, ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

  logic clk = 0, rst_n = 0;
  logic [4:0] mode = USR, wmode = USR;
  logic [3:0] ia = 0, ib = 0, iw = 0;
  logic we = 0, swe = 0;
  logic [DW-1:0] wd = 0, pc = 32'h0000_1000, swd = 0;
  logic [DW-1:0] da, db, sd;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  banked_regfile #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .rd_a_idx_i(ia), .rd_a_data_o(da), .rd_b_idx_i(ib), .rd_b_data_o(db),
    .wr_en_i(we), .wr_mode_i(wmode), .wr_idx_i(iw), .wr_data_i(wd), .pc_i(pc),
    .sps_we_i(swe), .sps_wdata_i(swd), .sps_rdata_o(sd)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] i, logic [DW-1:0] d);
    @(negedge clk); wmode = m; iw = i; wd = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(string req, logic [4:0] m, logic [3:0] i, logic [DW-1:0] exp);
    @(negedge clk); mode = m; ia = i; ib = i; #1;
    check(req, da, exp);
    check(req, db, exp);
  endtask

  task automatic sps_wr(logic [4:0] m, logic [DW-1:0] d);
    @(negedge clk); mode = m; swd = d; swe = 1;
    @(posedge clk); #1 swe = 0;
  endtask

  task automatic sps_rd(string req, logic [4:0] m, logic [DW-1:0] exp);
    @(negedge clk); mode = m; #1;
    check(req, sd, exp);
  endtask

  task automatic t_reset;
    rd("R1", USR, 4'd0, 0);
    rd("R1", SVC, 4'd13, 0);
    rd("R1", FIQ, 4'd9, 0);
    sps_rd("R1", FIQ, 0);
  endtask

  task automatic t_shared;
    wr(USR, 4'd3, 32'hA0A0_0003);
    wr(MON, 4'd7, 32'hA0A0_0007);
    rd("R2", FIQ, 4'd3, 32'hA0A0_0003);
    rd("R2", IRQ, 4'd3, 32'hA0A0_0003);
    rd("R2", USR, 4'd7, 32'hA0A0_0007);
    rd("R2", FIQ, 4'd7, 32'hA0A0_0007);
  endtask

  task automatic t_fiq;
    wr(USR, 4'd8,  32'hB000_0008);
    wr(USR, 4'd14, 32'hB000_000E);
    wr(FIQ, 4'd8,  32'hF000_0008);
    wr(FIQ, 4'd12, 32'hF000_000C);
    wr(FIQ, 4'd14, 32'hF000_000E);
    rd("R3", FIQ, 4'd8,  32'hF000_0008);
    rd("R3", FIQ, 4'd12, 32'hF000_000C);
    rd("R3", FIQ, 4'd14, 32'hF000_000E);
    rd("R3", USR, 4'd8,  32'hB000_0008);
    rd("R3", USR, 4'd12, 0);
    rd("R3", USR, 4'd14, 32'hB000_000E);
    rd("R4", IRQ, 4'd8,  32'hB000_0008);
  endtask

  task automatic t_bank13;
    logic [4:0] ms [5] = '{IRQ, SVC, ABT, UND, MON};
    wr(USR, 4'd13, 32'h5500_0000);
    for (int k = 0; k < 5; k++) wr(ms[k], 4'd13, 32'h1300_0000 + k);
    for (int k = 0; k < 5; k++) rd("R4", ms[k], 4'd13, 32'h1300_0000 + k);
    rd("R4", USR, 4'd13, 32'h5500_0000);
    rd("R4", FIQ, 4'd13, 0);
    wr(SVC, 4'd10, 32'h5C00_000A);
    rd("R4", USR, 4'd10, 32'h5C00_000A);
  endtask

  task automatic t_sys;
    wr(SYS, 4'd11, 32'h5757_000B);
    rd("R5", USR, 4'd11, 32'h5757_000B);
    rd("R5", SYS, 4'd13, 32'h5500_0000);
    rd("R5", 5'b00101, 4'd13, 32'h5500_0000);
    rd("R5", 5'b11000, 4'd14, 32'hB000_000E);
  endtask

  task automatic t_pc;
    pc = 32'h0000_BEEC;
    rd("R6", SVC, 4'd15, 32'h0000_BEEC);
    wr(USR, 4'd15, 32'hDEAD_DEAD);
    wr(MON, 4'd15, 32'hDEAD_DEAD);
    rd("R6", USR, 4'd15, 32'h0000_BEEC);
    rd("R6", USR, 4'd13, 32'h5500_0000);
    rd("R6", USR, 4'd14, 32'hB000_000E);
    rd("R6", MON, 4'd14, 0);
    rd("R6", USR, 4'd0, 0);
  endtask

  task automatic t_timing;
    @(negedge clk); mode = USR; ia = 4'd5; ib = 4'd5;
    wmode = USR; iw = 4'd5; wd = 32'h7777_0005; we = 1; #1;
    check("R7", da, 0);
    @(posedge clk); #1 we = 0;
    check("R7", da, 32'h7777_0005);
  endtask

  task automatic t_cross;
    wr(SVC, 4'd14, 32'hC0C0_E14E);
    rd("R8", USR, 4'd14, 32'hB000_000E);
    rd("R8", SVC, 4'd14, 32'hC0C0_E14E);
    rd("R8", ABT, 4'd14, 0);
  endtask

  task automatic t_sps;
    logic [4:0] ms [6] = '{FIQ, IRQ, SVC, ABT, UND, MON};
    for (int k = 0; k < 6; k++) sps_wr(ms[k], 32'h5050_0000 + k);
    for (int k = 0; k < 6; k++) sps_rd("R9", ms[k], 32'h5050_0000 + k);
  endtask

  task automatic t_sps_user;
    sps_wr(USR, 32'hFFFF_FFFF);
    sps_rd("R10", USR, 0);
    sps_wr(SYS, 32'hEEEE_EEEE);
    sps_rd("R10", SYS, 0);
    sps_rd("R10", 5'b00000, 0);
    sps_rd("R10", FIQ, 32'h5050_0000);
    sps_rd("R10", IRQ, 32'h5050_0001);
  endtask

  task automatic t_ports;
    @(negedge clk); mode = FIQ; ia = 4'd3; ib = 4'd8; #1;
    check("R11", da, 32'hA0A0_0003);
    check("R11", db, 32'hF000_0008);
    @(negedge clk); ia = 4'd15; ib = 4'd14; #1;
    check("R11", da, pc);
    check("R11", db, 32'hF000_000E);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_shared();
    t_fiq();
    t_bank13();
    t_sys();
    t_pc();
    t_timing();
    t_cross();
    t_sps();
    t_sps_user();
    t_ports();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule